// File: doc/BRIEF.md
# Master-Mode Audio Frame Clock Generator

This block derives the serial-audio timing clocks from a single master clock when the audio port runs as timing master. It drives one shared bit clock and two frame (left/right) clocks. The capture frame clock serves the converter input path and the playback frame clock serves the output path. Each side has its own 3-bit rate select. That select sets the frame length in master clocks, from 128 up to 768. Lengths that are not powers of two (192, 384, 768) are supported.

Every frame clock is a square wave with equal halves. It is low for the first half of a frame and high for the second half. The bit clock is tied to the playback side and gives 64 bit periods per playback frame. A new rate select takes effect only when the current frame ends, so no shortened half-periods appear. Some codes are legal for playback only. When the capture side is given one of those codes or an unused code, it parks its frame clock low and raises an error flag.

Top module: `smp_clk_gen`

## Requirements
- R1: Rate codes map to frame lengths in master clocks as follows: 3'b000=128, 3'b001=192, 3'b010=256, 3'b011=384, 3'b100=512, 3'b101=768. A frame clock is low for the first half of each frame and high for the second half.
- R2: The bit clock divides the master clock by playback frame length / 64, which is 2, 3, 4, 6, 8 or 12. Within each bit period it is low for the first ceil(div/2) master clocks and high for the remaining floor(div/2).
- R3: Every edge of the playback frame clock occurs in the same master-clock cycle as a falling edge of the bit clock.
- R4: A capture code of 3'b000, 3'b001, 3'b110 or 3'b111 seen at a capture frame boundary holds the capture frame clock low and sets the error output. The capture side re-evaluates its code every master clock while parked. A legal capture code (3'b010 to 3'b101) starts a new frame and clears the error.
- R5: Playback codes 3'b110 and 3'b111 are ignored. The playback side keeps its previous frame length, which is 256 after reset.
- R6: A rate-select change takes effect only at the next frame boundary of that side. The current frame always completes at its old length.
- R7: While rst_ni is low, all outputs are low. The first frame of each side begins on the first master-clock edge after reset is released.
- R8: The two sides keep separate rate selects. When both hold the same legal code from reset onward, the two frame clocks are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| play_rate_i | input | 3 | Playback frame-length code |
| cap_rate_i | input | 3 | Capture frame-length code |
| bclk_o | output | 1 | Bit clock, 64 per playback frame |
| play_lrclk_o | output | 1 | Playback frame clock |
| cap_lrclk_o | output | 1 | Capture frame clock |
| cap_err_o | output | 1 | Capture code rejected |

## Verification
A frame boundary can coincide with a rate-select change, and on the capture side a boundary can coincide with a legal code turning illegal. These are the cycles where reload and rejection decide the outcome together. The bench sweeps all 64 code pairs from reset. It then applies code changes at pseudo-random spacings, so many changes land exactly on a boundary cycle or just before one. Each cycle's outputs are judged against an arithmetic frame-position model that knows only the code table and the boundary rule.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int unsigned MAX_DIV  = 12;
  localparam int unsigned DIV_W    = $clog2(MAX_DIV + 1);
  localparam logic [2:0]  DEF_CODE = 3'b010;

  function automatic logic [DIV_W-1:0] code_div(input logic [2:0] c);
    logic [DIV_W-1:0] d;
    case (c)
      3'd0:    d = DIV_W'(2);
      3'd1:    d = DIV_W'(3);
      3'd2:    d = DIV_W'(4);
      3'd3:    d = DIV_W'(6);
      3'd4:    d = DIV_W'(8);
      3'd5:    d = DIV_W'(12);
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sclk_rate_dec.sv
module sclk_rate_dec
  import sclk_pkg::*;
#(
  parameter bit FAST_OK = 1'b1
) (
  input  logic [2:0]       code_i,
  output logic [DIV_W-1:0] div_o,
  output logic             ok_o
);
  assign div_o = code_div(code_i);

  generate
    if (FAST_OK) begin : g_fast
      assign ok_o = (code_i <= 3'd5);
    end else begin : g_slow
      assign ok_o = (code_i >= 3'd2) && (code_i <= 3'd5);
    end
  endgenerate
endmodule

// File: rtl/sclk_side.sv
module sclk_side
  import sclk_pkg::*;
#(
  parameter int unsigned FRAME_BCLKS = 64,
  parameter bit          PLAY_SIDE   = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] code_i,
  output logic       lr_o,
  output logic       bclk_o,
  output logic       err_o
);
  localparam int unsigned HALF  = FRAME_BCLKS / 2;
  localparam int unsigned CNT_W = $clog2(MAX_DIV * FRAME_BCLKS);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic [DIV_W-1:0] bc_q, bc_d, div_q, div_d, sel_div;
  logic             run_q, run_d, err_q, err_d, sel_ok;
  logic             lr_q, lr_d, bclk_q, bclk_d;

  sclk_rate_dec #(.FAST_OK(PLAY_SIDE)) u_dec (
    .code_i(code_i),
    .div_o (sel_div),
    .ok_o  (sel_ok)
  );

  always_comb begin
    rem_d = rem_q - CNT_W'(1);
    bc_d  = (bc_q == '0) ? div_q - DIV_W'(1) : bc_q - DIV_W'(1);
    div_d = div_q;
    run_d = run_q;
    err_d = err_q;
    if (rem_q == '0) begin
      if (sel_ok) begin
        div_d = sel_div;
        rem_d = CNT_W'(32'(sel_div) * FRAME_BCLKS - 32'd1);
        bc_d  = sel_div - DIV_W'(1);
        run_d = 1'b1;
        err_d = 1'b0;
      end else if (PLAY_SIDE) begin
        // bad playback code: keep running at the held length
        rem_d = CNT_W'(32'(div_q) * FRAME_BCLKS - 32'd1);
        bc_d  = div_q - DIV_W'(1);
        run_d = 1'b1;
      end else begin
        // bad capture code: park and retry next cycle
        rem_d = '0;
        bc_d  = '0;
        run_d = 1'b0;
        err_d = 1'b1;
      end
    end
    lr_d   = run_d && (rem_d < CNT_W'(32'(div_d) * HALF));
    bclk_d = run_d && (bc_d < (div_d >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      bc_q   <= '0;
      div_q  <= code_div(DEF_CODE);
      run_q  <= 1'b0;
      err_q  <= 1'b0;
      lr_q   <= 1'b0;
      bclk_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      bc_q   <= bc_d;
      div_q  <= div_d;
      run_q  <= run_d;
      err_q  <= err_d;
      lr_q   <= lr_d;
      bclk_q <= bclk_d;
    end
  end

  assign lr_o   = lr_q;
  assign bclk_o = bclk_q;

  generate
    if (PLAY_SIDE) begin : g_no_err
      logic unused_err;
      assign unused_err = err_q;
      assign err_o      = 1'b0;
    end else begin : g_err
      assign err_o = err_q;
    end
  endgenerate
endmodule

// File: rtl/smp_clk_gen.sv
module smp_clk_gen #(
  parameter int unsigned FRAME_BCLKS = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] play_rate_i,
  input  logic [2:0] cap_rate_i,
  output logic       bclk_o,
  output logic       play_lrclk_o,
  output logic       cap_lrclk_o,
  output logic       cap_err_o
);
  logic play_err, cap_bclk;
  logic unused_bits;

  sclk_side #(.FRAME_BCLKS(FRAME_BCLKS), .PLAY_SIDE(1'b1)) u_play (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(play_rate_i),
    .lr_o  (play_lrclk_o),
    .bclk_o(bclk_o),
    .err_o (play_err)
  );

  sclk_side #(.FRAME_BCLKS(FRAME_BCLKS), .PLAY_SIDE(1'b0)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(cap_rate_i),
    .lr_o  (cap_lrclk_o),
    .bclk_o(cap_bclk),
    .err_o (cap_err_o)
  );

  assign unused_bits = play_err ^ cap_bclk;
endmodule

// File: rtl/sclk_chk.sv
module sclk_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cap_rate_i,
  input logic       bclk_o,
  input logic       play_lrclk_o,
  input logic       cap_lrclk_o,
  input logic       cap_err_o
);
  // R3
  lr_on_bclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(play_lrclk_o) |-> $fell(bclk_o));

  // R4
  err_parks_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_err_o |-> !cap_lrclk_o);

  // R4
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_err_o) |-> ($past(cap_rate_i) inside {3'd0, 3'd1, 3'd6, 3'd7}));

  // R6
  play_no_runt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(play_lrclk_o) |=> $stable(play_lrclk_o));

  // R6
  cap_no_runt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_lrclk_o) |=> $stable(cap_lrclk_o));
endmodule

bind smp_clk_gen sclk_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cap_rate_i  (cap_rate_i),
  .bclk_o      (bclk_o),
  .play_lrclk_o(play_lrclk_o),
  .cap_lrclk_o (cap_lrclk_o),
  .cap_err_o   (cap_err_o)
);

// File: tb/sim_smp_clk_gen.sv
`timescale 1ns/1ps
module sim_smp_clk_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] play_rate = 3'd2;
  logic [2:0] cap_rate = 3'd2;
  logic       bclk, play_lr, cap_lr, cap_err;

  int checks = 0, failures = 0;
  bit checking = 0, eq_mode = 0, chg_phase = 0, done = 0;

  int p_rem = 0, p_div = 4, c_rem = 0, c_div = 4;
  bit p_run = 0, c_run = 0, c_err = 0;
  logic prev_lr = 1'b0, prev_bclk = 1'b0;

  always #4 clk = ~clk;

  smp_clk_gen u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .play_rate_i (play_rate),
    .cap_rate_i  (cap_rate),
    .bclk_o      (bclk),
    .play_lrclk_o(play_lr),
    .cap_lrclk_o (cap_lr),
    .cap_err_o   (cap_err)
  );

  function automatic int div_of(input logic [2:0] c);
    case (c)
      3'd0: return 2;
      3'd1: return 3;
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 8;
      default: return 12;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t act=%0b exp=%0b", req, $time, act, exp);
    end
  endtask

  // frame-position model: remaining master clocks in the current frame
  always @(posedge clk) begin
    if (!rst_ni) begin
      p_rem = 0; p_div = 4; p_run = 0;
      c_rem = 0; c_div = 4; c_run = 0; c_err = 0;
    end else begin
      if (p_rem == 0) begin
        if (play_rate <= 3'd5) p_div = div_of(play_rate);
        p_rem = p_div * 64 - 1;
        p_run = 1;
      end else p_rem--;
      if (c_rem == 0) begin
        if (cap_rate >= 3'd2 && cap_rate <= 3'd5) begin
          c_div = div_of(cap_rate);
          c_rem = c_div * 64 - 1;
          c_run = 1;
          c_err = 0;
        end else begin
          c_run = 0;
          c_err = 1;
        end
      end else c_rem--;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && checking) begin
      check(chg_phase ? "R6" : (play_rate > 3'd5 ? "R5" : "R1"),
            play_lr, p_run && (p_rem < p_div * 32));
      check("R2", bclk, p_run && ((p_rem % p_div) < p_div / 2));
      check((cap_rate < 3'd2 || cap_rate > 3'd5) ? "R4" : "R1",
            cap_lr, c_run && (c_rem < c_div * 32));
      check("R4", cap_err, c_err);
      if (play_lr !== prev_lr) check("R3", {prev_bclk, bclk} == 2'b10, 1'b1);
      if (eq_mode) check("R8", cap_lr, play_lr);
    end
    prev_lr   = play_lr;
    prev_bclk = bclk;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", {bclk, play_lr, cap_lr, cap_err} == 4'b0, 1'b1);
    for (int pc = 0; pc < 8; pc++) begin
      for (int cc = 0; cc < 8; cc++) begin
        @(negedge clk);
        rst_ni = 1'b0;
        checking = 0;
        play_rate = 3'(pc);
        cap_rate = 3'(cc);
        eq_mode = (pc == cc) && (pc >= 2) && (pc <= 5);
        @(negedge clk);
        check("R7", {bclk, play_lr, cap_lr, cap_err} == 4'b0, 1'b1);
        rst_ni = 1'b1;
        checking = 1;
        repeat (1560) @(negedge clk);
      end
    end
    // pseudo-random rate changes, many landing on or near a boundary
    @(negedge clk);
    rst_ni = 1'b0;
    checking = 0;
    eq_mode = 0;
    play_rate = 3'd2;
    cap_rate = 3'd3;
    @(negedge clk);
    rst_ni = 1'b1;
    checking = 1;
    chg_phase = 1;
    for (int i = 0; i < 60; i++) begin
      repeat (($urandom % 700) + 1) @(negedge clk);
      play_rate = 3'($urandom % 8);
      cap_rate = 3'($urandom % 8);
    end
    repeat (1600) @(negedge clk);
    checking = 0;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule